// File: doc/BRIEF.md
# Bus Master Address Tenure Sequencer

This block runs the master side of the address phase on a split-transaction processor bus. Transfer requests arrive from an internal queue through a valid/ready pair and are held in a small in-order slot store. Once a request is waiting and the bus is free, the block raises its bus request. In any cycle where the qualified grant is also present, it fires a one-cycle start strobe and drives the address and attributes of the oldest waiting transfer. It holds them until the address acknowledge closes the tenure. It then watches the retry input for one more cycle before it tells the queue that the transfer is finished.

A mode input selects one of two timings. In legacy mode a dead turnaround cycle follows every acknowledge, so a tenure spans at least three clocks. In streaming mode the next tenure may start in the cycle right after the acknowledge, so back-to-back tenures of two clocks are possible. A retry seen while a tenure is open, or in the cycle after its acknowledge, returns the affected transfers to the waiting state. The block then stays off the bus for one cycle and reissues them in their original order. Retry handling is the same in both modes.

Top module: `ats_addr_tenure_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, ts_strobe, req_done and bus_req are low and req_ready is high.
- R2: ts_strobe is high only in a cycle where bus_req and bus_grant are both high, and it never stays high for two cycles in a row. A waiting request with bus_grant low keeps bus_req high and produces no strobe.
- R3: In the strobe cycle, abus_addr and abus_attr equal the request being issued, and they hold those values in every cycle up to and including the acknowledge cycle.
- R4: aack closes a tenure only while one is open, and at most one tenure is open at a time. An aack in the strobe cycle itself, or with no tenure open, has no effect.
- R5: With stream_mode low, no strobe occurs in the cycle after an accepted acknowledge. Starts of consecutive tenures are therefore spaced by the acknowledge delay plus two cycles, and never by less than three.
- R6: With stream_mode high, a strobe may occur in the cycle right after an accepted acknowledge. Consecutive starts are spaced by the acknowledge delay plus one cycle, which is two cycles when the acknowledge is not delayed.
- R7: An aretry during an open tenure (including its strobe cycle), or in the cycle after its acknowledge, marks that transfer as not done. The transfer is later reissued with the same address, and transfer order is preserved. In streaming mode, a retry in a transfer's post-acknowledge cycle also cancels a tenure that starts in that same cycle.
- R8: In the cycle after a retry takes effect, bus_req and ts_strobe are low.
- R9: req_done pulses for exactly one cycle per transfer, in the cycle after its accepted acknowledge, and only when aretry is low in that cycle.
- R10: An aretry while no tenure is open, no post-acknowledge cycle is running and no strobe is issued has no effect: a waiting request keeps bus_req high in the next cycle.
- R11: The block holds up to NSLOT (default 2) transfers. req_ready is high exactly when the last slot is empty, and a request is taken on a cycle with req_valid and req_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| stream_mode | input | 1 | 1 = streaming tenures, 0 = legacy with turnaround |
| req_valid | input | 1 | Queue has a transfer to issue |
| req_addr | input | AW | Address of the offered transfer |
| req_attr | input | TW | Transfer attributes of the offered transfer |
| req_ready | output | 1 | Block takes the offered transfer this cycle |
| req_done | output | 1 | Oldest transfer completed without retry |
| bus_req | output | 1 | Block wants the address bus |
| bus_grant | input | 1 | Qualified address bus grant |
| ts_strobe | output | 1 | One-cycle transfer start strobe |
| abus_addr | output | AW | Address driven during the tenure |
| abus_attr | output | TW | Attributes driven during the tenure |
| aack | input | 1 | Address acknowledge, ends the tenure |
| aretry | input | 1 | Address retry |

## Verification
The bound checker watches on every cycle that strobes appear only under grant and never during an open tenure, that address and attributes hold until the acknowledge, that no strobe follows an acknowledge in legacy mode, that the bus stays idle after a retry, and that the done pulse coincides exactly with a retry-free post-acknowledge cycle. Only the bench scenarios can show the tenure spacing for each mode and each acknowledge delay, the reissue order after retries in the tenure and in the window (including the streaming case where a retry cancels the tenure started in the same cycle), that an acknowledge landing on a reissue strobe is ignored, and that a stray retry leaves a waiting request unaffected.

// File: rtl/ats_pkg.sv
package ats_pkg;

    // Life cycle of one held transfer.
    typedef enum logic [1:0] {
        SL_EMPTY = 2'd0,
        SL_WAIT  = 2'd1,
        SL_TEN   = 2'd2,
        SL_WIN   = 2'd3
    } slot_st_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ats_slot_file.sv
module ats_slot_file
    import ats_pkg::*;
#(
    parameter int AW    = 32,
    parameter int TW    = 5,
    parameter int NSLOT = 2,
    localparam int IW   = idx_width(NSLOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [IW-1:0] start_idx,
    input  logic          ack,
    input  logic          retry_eff,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [TW-1:0] load_attr,
    output slot_st_e      st   [NSLOT],
    output logic [AW-1:0] addr [NSLOT],
    output logic [TW-1:0] attr [NSLOT],
    output logic          pop
);

    slot_st_e      upd    [NSLOT];
    slot_st_e      sh_st  [NSLOT];
    logic [AW-1:0] sh_addr[NSLOT];
    logic [TW-1:0] sh_attr[NSLOT];
    slot_st_e      n_st   [NSLOT];
    logic [AW-1:0] n_addr [NSLOT];
    logic [TW-1:0] n_attr [NSLOT];

    // Oldest slot leaves once its window passes without retry.
    assign pop = (st[0] == SL_WIN) && !retry_eff;

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            upd[i] = st[i];
            if (retry_eff && (st[i] == SL_TEN || st[i] == SL_WIN))
                upd[i] = SL_WAIT;
            else if (!retry_eff && start && start_idx == IW'(i))
                upd[i] = SL_TEN;
            else if (!retry_eff && ack && st[i] == SL_TEN)
                upd[i] = SL_WIN;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_shift
        if (g + 1 < NSLOT) begin : g_mid
            assign sh_st[g]   = pop ? upd[g+1]  : upd[g];
            assign sh_addr[g] = pop ? addr[g+1] : addr[g];
            assign sh_attr[g] = pop ? attr[g+1] : attr[g];
        end else begin : g_last
            assign sh_st[g]   = pop ? SL_EMPTY : upd[g];
            assign sh_addr[g] = addr[g];
            assign sh_attr[g] = attr[g];
        end
    end

    always_comb begin
        logic placed;
        placed = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            n_st[i]   = sh_st[i];
            n_addr[i] = sh_addr[i];
            n_attr[i] = sh_attr[i];
            if (load && !placed && sh_st[i] == SL_EMPTY) begin
                placed    = 1'b1;
                n_st[i]   = SL_WAIT;
                n_addr[i] = load_addr;
                n_attr[i] = load_attr;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NSLOT; i++) begin
            if (rst) begin
                st[i]   <= SL_EMPTY;
                addr[i] <= '0;
                attr[i] <= '0;
            end else begin
                st[i]   <= n_st[i];
                addr[i] <= n_addr[i];
                attr[i] <= n_attr[i];
            end
        end
    end

endmodule

// File: rtl/ats_issue_ctrl.sv
module ats_issue_ctrl
    import ats_pkg::*;
#(
    parameter int NSLOT = 2,
    localparam int IW   = idx_width(NSLOT)
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_st_e      st [NSLOT],
    input  logic          stream,
    input  logic          grant,
    input  logic          retry,
    output logic          bus_req,
    output logic          start,
    output logic [IW-1:0] start_idx,
    output logic [IW-1:0] ten_idx,
    output logic          retry_eff
);

    logic any_ten, any_win, has_wait, backoff_q;

    always_comb begin
        any_ten   = 1'b0;
        any_win   = 1'b0;
        has_wait  = 1'b0;
        start_idx = '0;
        ten_idx   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (st[i] == SL_TEN) begin
                any_ten = 1'b1;
                ten_idx = IW'(i);
            end
            if (st[i] == SL_WIN)
                any_win = 1'b1;
            if (st[i] == SL_WAIT && !has_wait) begin
                has_wait  = 1'b1;
                start_idx = IW'(i);
            end
        end
    end

    // Legacy mode keeps the bus idle during the post-acknowledge cycle.
    assign bus_req   = has_wait && !backoff_q && !any_ten && (stream || !any_win);
    assign start     = bus_req && grant;
    assign retry_eff = retry && (any_ten || any_win || start);

    always_ff @(posedge clk) begin
        if (rst) backoff_q <= 1'b0;
        else     backoff_q <= retry_eff;
    end

endmodule

// File: rtl/ats_addr_tenure_seq.sv
module ats_addr_tenure_seq
    import ats_pkg::*;
#(
    parameter int AW    = 32,
    parameter int TW    = 5,
    parameter int NSLOT = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          stream_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] req_attr,
    output logic          req_ready,
    output logic          req_done,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          ts_strobe,
    output logic [AW-1:0] abus_addr,
    output logic [TW-1:0] abus_attr,
    input  logic          aack,
    input  logic          aretry
);

    localparam int IW = idx_width(NSLOT);

    slot_st_e      st    [NSLOT];
    logic [AW-1:0] s_addr[NSLOT];
    logic [TW-1:0] s_attr[NSLOT];
    logic [IW-1:0] start_idx, ten_idx, sel;
    logic          start, retry_eff, pop, load;

    assign req_ready = (st[NSLOT-1] == SL_EMPTY);
    assign load      = req_valid && req_ready;

    ats_issue_ctrl #(.NSLOT(NSLOT)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .stream   (stream_mode),
        .grant    (bus_grant),
        .retry    (aretry),
        .bus_req  (bus_req),
        .start    (start),
        .start_idx(start_idx),
        .ten_idx  (ten_idx),
        .retry_eff(retry_eff)
    );

    ats_slot_file #(.AW(AW), .TW(TW), .NSLOT(NSLOT)) u_slots (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .start_idx(start_idx),
        .ack      (aack),
        .retry_eff(retry_eff),
        .load     (load),
        .load_addr(req_addr),
        .load_attr(req_attr),
        .st       (st),
        .addr     (s_addr),
        .attr     (s_attr),
        .pop      (pop)
    );

    assign sel       = start ? start_idx : ten_idx;
    assign abus_addr = s_addr[sel];
    assign abus_attr = s_attr[sel];
    assign ts_strobe = start;
    assign req_done  = pop;

endmodule

// File: rtl/ats_seq_checker.sv
module ats_seq_checker #(
    parameter int AW = 32,
    parameter int TW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          stream_mode,
    input logic          bus_grant,
    input logic          bus_req,
    input logic          ts_strobe,
    input logic          req_done,
    input logic          aack,
    input logic          aretry,
    input logic [AW-1:0] abus_addr,
    input logic [TW-1:0] abus_attr
);

    logic ten_chk, win_chk, retry_hit;

    assign retry_hit = aretry && (ten_chk || win_chk || ts_strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            ten_chk <= 1'b0;
            win_chk <= 1'b0;
        end else begin
            win_chk <= !retry_hit && aack && ten_chk;
            if (retry_hit)              ten_chk <= 1'b0;
            else if (ts_strobe)         ten_chk <= 1'b1;
            else if (aack && ten_chk)   ten_chk <= 1'b0;
        end
    end

    p_strobe_granted_r2: assert property (@(posedge clk) disable iff (rst)
        ts_strobe |-> (bus_grant && bus_req));

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
        ts_strobe |=> !ts_strobe);

    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        ten_chk |-> ($stable(abus_addr) && $stable(abus_attr)));

    p_one_tenure_r4: assert property (@(posedge clk) disable iff (rst)
        ten_chk |-> !ts_strobe);

    p_legacy_turn_r5: assert property (@(posedge clk) disable iff (rst)
        (!stream_mode && win_chk) |-> !ts_strobe);

    p_retry_no_done_r7: assert property (@(posedge clk) disable iff (rst)
        aretry |-> !req_done);

    p_backoff_r8: assert property (@(posedge clk) disable iff (rst)
        retry_hit |=> (!ts_strobe && !bus_req));

    p_done_in_window_r9: assert property (@(posedge clk) disable iff (rst)
        req_done |-> (win_chk && !aretry));

    p_window_gives_done_r9: assert property (@(posedge clk) disable iff (rst)
        (win_chk && !aretry) |-> req_done);

endmodule

bind ats_addr_tenure_seq ats_seq_checker #(.AW(AW), .TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .stream_mode(stream_mode),
    .bus_grant  (bus_grant),
    .bus_req    (bus_req),
    .ts_strobe  (ts_strobe),
    .req_done   (req_done),
    .aack       (aack),
    .aretry     (aretry),
    .abus_addr  (abus_addr),
    .abus_attr  (abus_attr)
);

// File: tb/sim_ats_addr_tenure_seq.sv
`timescale 1ns/1ps
module sim_ats_addr_tenure_seq;

    localparam int AW = 32;
    localparam int TW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stream_mode = 1'b0;
    logic req_valid = 1'b0, bus_grant = 1'b0, aack = 1'b0, aretry = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_attr = '0;
    logic req_ready, req_done, bus_req, ts_strobe;
    logic [AW-1:0] abus_addr;
    logic [TW-1:0] abus_attr;

    always #2.5 clk = ~clk;

    ats_addr_tenure_seq #(.AW(AW), .TW(TW)) u0 (
        .clk(clk), .rst(rst), .stream_mode(stream_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_attr(req_attr),
        .req_ready(req_ready), .req_done(req_done), .bus_req(bus_req),
        .bus_grant(bus_grant), .ts_strobe(ts_strobe),
        .abus_addr(abus_addr), .abus_attr(abus_attr),
        .aack(aack), .aretry(aretry)
    );

    typedef struct { logic [AW-1:0] a; logic [TW-1:0] t; } rq_t;
    typedef struct { logic [AW-1:0] a; logic [TW-1:0] t; int st; } mx_t;

    rq_t  src[$];
    mx_t  mq[$];
    bit   m_bo;
    int   n_chk = 0, n_fail = 0, cyc = 0;
    int   ack_due = -10, retry_due = -10;
    int   ack_delay = 1, retry_off = 2, retry_budget = 0;
    bit   grant_en = 0, frc_ack = 0, frc_retry = 0, finished = 0;
    logic [AW-1:0] log_a[$];
    int   log_c[$];
    int   dn_cnt = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Stimulus driven one ns after each rising edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        req_valid = (src.size() > 0);
        req_addr  = (src.size() > 0) ? src[0].a : '0;
        req_attr  = (src.size() > 0) ? src[0].t : '0;
        bus_grant = grant_en;
        aack      = frc_ack   || (cyc == ack_due);
        aretry    = frc_retry || (cyc == retry_due);
    end

    // Behavioural reference, compared at each falling edge.
    always @(negedge clk) begin
        int wi, ti;
        bit at, aw, e_req, e_st, r_eff, e_dn, e_rdy;
        if (rst) begin
            mq.delete();
            m_bo = 0;
        end else begin
            wi = -1; ti = -1; at = 0; aw = 0;
            foreach (mq[i]) begin
                if (mq[i].st == 1) begin at = 1; ti = i; end
                if (mq[i].st == 2) aw = 1;
                if (mq[i].st == 0 && wi < 0) wi = i;
            end
            e_req = (wi >= 0) && !m_bo && !at && (stream_mode || !aw);
            e_st  = e_req && bus_grant;
            r_eff = aretry && (at || aw || e_st);
            e_dn  = (mq.size() > 0) && (mq[0].st == 2) && !r_eff;
            e_rdy = (mq.size() < 2);

            chk(ts_strobe == e_st, "R2", "strobe", ts_strobe, e_st);
            chk(bus_req == e_req, "R8", "bus_req", bus_req, e_req);
            chk(req_done == e_dn, "R9", "done", req_done, e_dn);
            chk(req_ready == e_rdy, "R11", "ready", req_ready, e_rdy);
            if (e_st) begin
                chk(abus_addr == mq[wi].a, "R3", "start addr", abus_addr, mq[wi].a);
                chk(abus_attr == mq[wi].t, "R3", "start attr", abus_attr, mq[wi].t);
            end else if (at) begin
                chk(abus_addr == mq[ti].a, "R3", "held addr", abus_addr, mq[ti].a);
            end

            if (ts_strobe) begin
                log_a.push_back(abus_addr);
                log_c.push_back(cyc);
                ack_due = cyc + ack_delay;
                if (retry_budget > 0) begin
                    retry_budget--;
                    retry_due = cyc + retry_off;
                end
            end
            if (req_done) dn_cnt++;

            foreach (mq[i]) begin
                if (r_eff && (mq[i].st == 1 || mq[i].st == 2)) mq[i].st = 0;
                else if (!r_eff && e_st && i == wi)             mq[i].st = 1;
                else if (!r_eff && aack && mq[i].st == 1)       mq[i].st = 2;
            end
            if (e_dn) void'(mq.pop_front());
            if (req_valid && e_rdy) mq.push_back('{req_addr, req_attr, 0});
            m_bo = r_eff;
            if (req_valid && req_ready) void'(src.pop_front());
        end
    end

    task automatic do_reset(input bit strm);
        rst = 1'b1;
        grant_en = 0;
        ack_due = -10;
        retry_due = -10;
        retry_budget = 0;
        stream_mode = strm;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        log_a.delete();
        log_c.delete();
        dn_cnt = 0;
    endtask

    task automatic run_case(input bit strm, input int n, input int delay,
                            input int roff, input int rbud);
        int guard;
        do_reset(strm);
        ack_delay = delay;
        retry_off = roff;
        retry_budget = rbud;
        grant_en = 1;
        for (int i = 0; i < n; i++)
            src.push_back('{32'h1000 + AW'(i * 16) + (strm ? 32'h100 : 32'h0), TW'(i + 1)});
        guard = 0;
        while (dn_cnt < n && guard < 300) begin
            @(posedge clk);
            guard++;
        end
        repeat (4) @(posedge clk);
    endtask

    task automatic check_gaps(input int gap, input string tag);
        for (int i = 1; i < log_c.size(); i++)
            chk(log_c[i] - log_c[i-1] == gap, tag, "start spacing",
                log_c[i] - log_c[i-1], gap);
    endtask

    initial begin
        // R1: reset values
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(ts_strobe == 0, "R1", "reset strobe", ts_strobe, 0);
        chk(req_done == 0, "R1", "reset done", req_done, 0);
        chk(bus_req == 0, "R1", "reset bus_req", bus_req, 0);
        chk(req_ready == 1, "R1", "reset ready", req_ready, 1);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(bus_req == 0 && ts_strobe == 0, "R1", "after reset idle", bus_req, 0);

        // R5: legacy, prompt and late acknowledge
        run_case(0, 3, 1, 2, 0);
        chk(log_c.size() == 3, "R5", "legacy starts", log_c.size(), 3);
        check_gaps(3, "R5");
        chk(dn_cnt == 3, "R9", "legacy done count", dn_cnt, 3);
        run_case(0, 3, 3, 4, 0);
        check_gaps(5, "R5");

        // R6: streaming, back-to-back
        run_case(1, 4, 1, 2, 0);
        chk(log_c.size() == 4, "R6", "stream starts", log_c.size(), 4);
        check_gaps(2, "R6");
        chk(dn_cnt == 4, "R9", "stream done count", dn_cnt, 4);
        run_case(1, 3, 2, 3, 0);
        check_gaps(3, "R6");

        // R7: legacy retry in the post-acknowledge cycle
        run_case(0, 2, 1, 2, 1);
        chk(log_a.size() == 3, "R7", "legacy window retry starts", log_a.size(), 3);
        if (log_a.size() == 3) begin
            chk(log_a[0] == 32'h1000 && log_a[1] == 32'h1000, "R7", "reissue addr", log_a[1], 32'h1000);
            chk(log_a[2] == 32'h1010, "R7", "next addr", log_a[2], 32'h1010);
            chk(log_c[1] - log_c[0] == 4, "R8", "retry spacing", log_c[1] - log_c[0], 4);
        end
        chk(dn_cnt == 2, "R7", "legacy retry done count", dn_cnt, 2);

        // R7/R4: retry mid-tenure; stale ack lands on the reissue strobe
        run_case(0, 2, 3, 1, 1);
        chk(log_a.size() == 3, "R7", "tenure retry starts", log_a.size(), 3);
        if (log_a.size() == 3) begin
            chk(log_a[1] == 32'h1000, "R7", "tenure reissue addr", log_a[1], 32'h1000);
            chk(log_c[2] - log_c[1] == 5, "R4", "ack in strobe cycle ignored", log_c[2] - log_c[1], 5);
        end
        chk(dn_cnt == 2, "R4", "tenure retry done count", dn_cnt, 2);

        // R7: streaming retry cancels the tenure started in the window
        run_case(1, 3, 1, 2, 1);
        chk(log_a.size() == 5, "R7", "stream retry starts", log_a.size(), 5);
        if (log_a.size() == 5) begin
            chk(log_a[1] == 32'h1110, "R7", "cancelled start", log_a[1], 32'h1110);
            chk(log_a[2] == 32'h1100, "R7", "first reissue", log_a[2], 32'h1100);
            chk(log_a[3] == 32'h1110, "R7", "second reissue", log_a[3], 32'h1110);
            chk(log_a[4] == 32'h1120, "R7", "order kept", log_a[4], 32'h1120);
        end
        chk(dn_cnt == 3, "R9", "stream retry done count", dn_cnt, 3);

        // R2, R10, R4: no grant, stray retry and stray acknowledge
        do_reset(0);
        ack_delay = 2;
        src.push_back('{32'h2000, 5'h1f});
        repeat (6) @(posedge clk);
        @(negedge clk);
        chk(log_c.size() == 0, "R2", "no strobe without grant", log_c.size(), 0);
        chk(bus_req == 1, "R2", "request pending", bus_req, 1);
        @(posedge clk);
        frc_retry = 1;
        @(posedge clk);
        frc_retry = 0;
        @(negedge clk);
        chk(bus_req == 1, "R10", "stray retry ignored", bus_req, 1);
        @(posedge clk);
        frc_ack = 1;
        @(posedge clk);
        frc_ack = 0;
        @(negedge clk);
        chk(dn_cnt == 0, "R4", "stray ack ignored", dn_cnt, 0);
        grant_en = 1;
        repeat (8) @(posedge clk);
        chk(log_a.size() == 1, "R2", "start after grant", log_a.size(), 1);
        chk(dn_cnt == 1, "R9", "single done", dn_cnt, 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule